// File: doc/BRIEF.md
# Register-access SPI slave with descending bursts

This block is the serial register port of a mixed-signal sensor die. A host drives a four-wire SPI bus in mode 0, with one data line in and one data line out. Each transfer opens with a sixteen-bit instruction: a direction bit, then a fifteen-bit byte address. Eight-bit data bytes follow. While chip select stays low the block keeps moving bytes, and after each byte it steps the address down by one. Stepping down from the bottom of the address space wraps to the top.

The bus pins are sampled by the system clock. Each of SCLK high and SCLK low must last at least four system clocks. Inside, the block holds the interface option registers, read-only identification bytes, a configuration byte with separate shadow and live copies, a strobe that copies the shadow into the live copy, and a soft-reset command. A configurable address window is passed to an external byte port, where the sampled data registers live. The external source must return read data one clock after its read strobe.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame starts when chip select falls. Data-in is sampled on SCLK rising edges. The first instruction bit is the direction (1 = read, 0 = write), followed by address bits 14 down to 0, most significant first.
- R2: Read data leaves on data-out most significant bit first. Each bit changes after a SCLK falling edge, and the first bit follows the fall after the sixteenth rise. Data-out is 0 during the instruction, during write frames and whenever chip select is high.
- R3: Every completed data byte moves the address down by one. The step below 0x0000 gives 0x7FFF.
- R4: Address 0x0000 always reads 0x18. Writing a byte with bit 7 set there issues a one-clock soft-reset pulse. The bit never reads back as 1.
- R5: A soft reset clears the shadow and live configuration bytes. It does not change the option register at 0x0001 or the frame in progress.
- R6: Writes to 0x0100 go to the shadow copy only. Writing a byte with bit 0 set to 0x000F copies the shadow into the live copy, which drives the cfg_active port. Address 0x000F always reads 0x00.
- R7: In the option register at 0x0001, only bit 5 is writable; all other bits read 0. When bit 5 is 0, reads of 0x0100 return the live copy. When bit 5 is 1, they return the shadow copy.
- R8: The identification bytes are 0x07 at 0x0003, 0x00 at 0x0004, 0x04 at 0x0005, 0x01 at 0x0006, 0x51 at 0x000C and 0x04 at 0x000D.
- R9: Writes to read-only or unmapped addresses have no effect. Reads of unmapped addresses return 0x00.
- R10: Addresses from EXT_LO to EXT_HI are served by the external port. A read strobe is issued with the address, and the data is taken one clock later. A write strobe carries the address and the data.
- R11: If chip select rises before a data byte is complete, that byte is dropped and nothing is written.
- R12: A high level on rst returns every register and data-out to its default value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high hardware reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, registered |
| ext_addr | output | 15 | Address for the external byte port |
| ext_rd | output | 1 | External read strobe |
| ext_rdata | input | 8 | External read data, valid one clock after ext_rd |
| ext_wr | output | 1 | External write strobe |
| ext_wdata | output | 8 | External write data |
| cfg_active | output | 8 | Live copy of the configuration byte |
| soft_rst | output | 1 | One-clock soft-reset pulse |

## Verification
A SCLK edge takes two synchronizer clocks before the frame logic sees it. A write lands in the register bank two clocks after that rise is detected. Read data is loaded into the transmit shifter two clocks after its request. A data-out bit appears one clock after its falling edge is seen. The bench holds each SCLK phase for six clocks and samples data-out at the end of the low phase, just before the next rise. It checks register state and cfg_active only after chip select has risen and several more clocks have passed, so every pipeline stage has settled by then.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int INS_W  = ADDR_W + 1;

  typedef enum logic {PH_CMD, PH_DATA} phase_t;

  localparam logic [ADDR_W-1:0] A_IFCFG  = 15'h0000;
  localparam logic [ADDR_W-1:0] A_IFOPT  = 15'h0001;
  localparam logic [ADDR_W-1:0] A_KIND   = 15'h0003;
  localparam logic [ADDR_W-1:0] A_IDLO   = 15'h0004;
  localparam logic [ADDR_W-1:0] A_IDHI   = 15'h0005;
  localparam logic [ADDR_W-1:0] A_REV    = 15'h0006;
  localparam logic [ADDR_W-1:0] A_VNDLO  = 15'h000C;
  localparam logic [ADDR_W-1:0] A_VNDHI  = 15'h000D;
  localparam logic [ADDR_W-1:0] A_COMMIT = 15'h000F;
  localparam logic [ADDR_W-1:0] A_CFG    = 15'h0100;

  localparam logic [DATA_W-1:0] V_IFCFG = 8'h18;
  localparam logic [DATA_W-1:0] V_KIND  = 8'h07;
  localparam logic [DATA_W-1:0] V_IDLO  = 8'h00;
  localparam logic [DATA_W-1:0] V_IDHI  = 8'h04;
  localparam logic [DATA_W-1:0] V_REV   = 8'h01;
  localparam logic [DATA_W-1:0] V_VNDLO = 8'h51;
  localparam logic [DATA_W-1:0] V_VNDHI = 8'h04;

  localparam int SRST_BIT = 7;
  localparam int RBSEL_BIT = 5;
  localparam int COMMIT_BIT = 0;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam logic [2:0] IDLE_VEC = 3'b010;

  logic [2:0] chain [STAGES];
  logic       sck_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= IDLE_VEC;
          else     chain[g] <= {sck, csn, mosi};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= IDLE_VEC;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= chain[STAGES-1][2];
  end

  assign sck_rise = chain[STAGES-1][2] & ~sck_prev;
  assign sck_fall = ~chain[STAGES-1][2] & sck_prev;
  assign cs_act   = ~chain[STAGES-1][1];
  assign mosi_s   = chain[STAGES-1][0];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_act,
  input  logic              mosi_s,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso
);
  localparam logic [3:0] CMD_LAST  = 4'(INS_W - 1);
  localparam logic [3:0] BYTE_LAST = 4'(DATA_W - 1);

  phase_t            phase;
  logic [3:0]        bit_cnt;
  logic [INS_W-2:0]  ins_sh;
  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_req_q, rd_req_q, miso_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      ins_sh    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rw_q      <= 1'b0;
      addr_q    <= '0;
      wr_req_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      miso_q    <= 1'b0;
    end else begin
      wr_req_q <= 1'b0;
      rd_req_q <= 1'b0;
      if (!cs_act) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        tx_sh   <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (sck_rise) begin
          if (phase == PH_CMD) begin
            ins_sh  <= {ins_sh[INS_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == CMD_LAST) begin
              rw_q     <= ins_sh[INS_W-2];
              addr_q   <= {ins_sh[ADDR_W-2:0], mosi_s};
              phase    <= PH_DATA;
              bit_cnt  <= '0;
              rd_req_q <= ins_sh[INS_W-2];
            end
          end else begin
            rx_sh   <= {rx_sh[DATA_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == BYTE_LAST) begin
              bit_cnt <= '0;
              addr_q  <= addr_q - 1'b1;
              if (rw_q) begin
                rd_req_q <= 1'b1;
              end else begin
                wr_req_q  <= 1'b1;
                wr_addr_q <= addr_q;
                wr_data_q <= {rx_sh, mosi_s};
              end
            end
          end
        end
        if (rd_valid) begin
          tx_sh <= rd_data;
        end else if (sck_fall && phase == PH_DATA && rw_q) begin
          miso_q <= tx_sh[DATA_W-1];
          tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign wr_req  = wr_req_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign rd_req  = rd_req_q;
  assign rd_addr = addr_q;
  assign miso    = miso_q;

  p_miso_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso_q);
  p_byte_cnt_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA) |-> (bit_cnt <= BYTE_LAST));
  p_wr_in_frame_r11: assert property (@(posedge clk) disable iff (rst)
    wr_req_q |-> $past(cs_act));
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter logic [14:0] EXT_LO = 15'h0200,
  parameter logic [14:0] EXT_HI = 15'h02FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ext_wr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic [DATA_W-1:0] cfg_active,
  output logic              soft_rst
);
  logic              rb_sel;
  logic [DATA_W-1:0] cfg_buf, cfg_act;
  logic              soft_q;
  logic              wr_ext, rd_ext;
  logic [DATA_W-1:0] int_rdata, int_q;
  logic              rd_valid_q, rd_ext_q;

  assign wr_ext = (wr_addr >= EXT_LO) && (wr_addr <= EXT_HI);
  assign rd_ext = (rd_addr >= EXT_LO) && (rd_addr <= EXT_HI);

  assign ext_wr    = wr_req & wr_ext;
  assign ext_rd    = rd_req & rd_ext;
  assign ext_addr  = rd_req ? rd_addr : wr_addr;
  assign ext_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_sel  <= 1'b0;
      cfg_buf <= '0;
      cfg_act <= '0;
      soft_q  <= 1'b0;
    end else begin
      soft_q <= 1'b0;
      if (soft_q) begin
        cfg_buf <= '0;
        cfg_act <= '0;
      end else if (wr_req && !wr_ext) begin
        case (wr_addr)
          A_IFCFG:  soft_q  <= wr_data[SRST_BIT];
          A_IFOPT:  rb_sel  <= wr_data[RBSEL_BIT];
          A_COMMIT: if (wr_data[COMMIT_BIT]) cfg_act <= cfg_buf;
          A_CFG:    cfg_buf <= wr_data;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_IFCFG: int_rdata = V_IFCFG;
      A_IFOPT: int_rdata = DATA_W'(rb_sel) << RBSEL_BIT;
      A_KIND:  int_rdata = V_KIND;
      A_IDLO:  int_rdata = V_IDLO;
      A_IDHI:  int_rdata = V_IDHI;
      A_REV:   int_rdata = V_REV;
      A_VNDLO: int_rdata = V_VNDLO;
      A_VNDHI: int_rdata = V_VNDHI;
      A_CFG:   int_rdata = rb_sel ? cfg_buf : cfg_act;
      default: int_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_ext_q   <= 1'b0;
      int_q      <= '0;
    end else begin
      rd_valid_q <= rd_req;
      rd_ext_q   <= ext_rd;
      int_q      <= int_rdata;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_ext_q ? ext_rdata : int_q;
  assign cfg_active = cfg_act;
  assign soft_rst   = soft_q;

  p_upd_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ext && wr_addr == A_COMMIT && wr_data[COMMIT_BIT] && !soft_q)
      |=> (cfg_act == $past(cfg_buf)));
  p_soft_clear_r5: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> (cfg_act == '0 && cfg_buf == '0));
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> $stable(rb_sel));
  p_rd_resp_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid_q);
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [14:0] EXT_LO      = 15'h0200,
  parameter logic [14:0] EXT_HI      = 15'h02FF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_sck,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [14:0] ext_addr,
  output logic        ext_rd,
  input  logic [7:0]  ext_rdata,
  output logic        ext_wr,
  output logic [7:0]  ext_wdata,
  output logic [7:0]  cfg_active,
  output logic        soft_rst
);
  logic              sck_rise, sck_fall, cs_act, mosi_s;
  logic              wr_req, rd_req, rd_valid;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_frame_engine u_eng (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .mosi_s(mosi_s),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .miso(spi_miso)
  );

  spi_cfg_regs #(.EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_regs (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_rdata(ext_rdata),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata),
    .cfg_active(cfg_active), .soft_rst(soft_rst)
  );
endmodule

// File: tb/spi_cfg_slave_tb.sv
module spi_cfg_slave_tb;
  localparam int HALF = 6;
  localparam logic [14:0] WIN_LO = 15'h0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic [14:0] ext_addr;
  logic        ext_rd, ext_wr, soft_rst;
  logic [7:0]  ext_rdata, ext_wdata, cfg_active;

  always #4 clk = ~clk;

  spi_cfg_slave #(.EXT_LO(WIN_LO), .EXT_HI(15'h7FFF)) u_dut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .ext_addr(ext_addr), .ext_rd(ext_rd), .ext_rdata(ext_rdata),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata), .cfg_active(cfg_active), .soft_rst(soft_rst)
  );

  int n_chk = 0, n_fail = 0, n_soft = 0, n_wr = 0, cmd_hi = 0;
  logic [14:0] wl_addr [16];
  logic [7:0]  wl_data [16];
  logic [7:0]  wb [8];
  logic [7:0]  rb [8];
  logic        m_sel = 1'b0;
  logic [7:0]  m_buf = 8'h00, m_act = 8'h00;

  function automatic logic [7:0] ext_fn(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] exp_reg(input logic [14:0] a);
    if (a >= WIN_LO) return ext_fn(a);
    case (a)
      15'h0000: return 8'h18;
      15'h0001: return m_sel ? 8'h20 : 8'h00;
      15'h0003: return 8'h07;
      15'h0004: return 8'h00;
      15'h0005: return 8'h04;
      15'h0006: return 8'h01;
      15'h000C: return 8'h51;
      15'h000D: return 8'h04;
      15'h0100: return m_sel ? m_buf : m_act;
      default:  return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) ext_rdata <= 8'h00;
    else if (ext_rd) ext_rdata <= ext_fn(ext_addr);
    if (soft_rst) n_soft <= n_soft + 1;
    if (ext_wr && n_wr < 16) begin
      wl_addr[n_wr] <= ext_addr;
      wl_data[n_wr] <= ext_wdata;
      n_wr <= n_wr + 1;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    r = spi_miso;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  // cut < 0: full frame of nbytes; otherwise chip select rises after cut data bits
  task automatic frame(input logic rw, input logic [14:0] a, input int nbytes, input int cut);
    logic r;
    logic [15:0] ins;
    int total;
    ins = {rw, a};
    total = (cut >= 0) ? cut : nbytes * 8;
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      spi_bit(ins[i], r);
      if (r) cmd_hi++;
    end
    for (int k = 0; k < total; k++) begin
      spi_bit(wb[k/8][7 - (k%8)], r);
      rb[k/8][7 - (k%8)] = r;
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic wr1(input logic [14:0] a, input logic [7:0] d);
    wb[0] = d;
    frame(1'b0, a, 1, -1);
  endtask

  task automatic rd1(input logic [14:0] a, output logic [7:0] d);
    wb[0] = 8'h00;
    frame(1'b1, a, 1, -1);
    d = rb[0];
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    int w0;
    repeat (5) @(negedge clk);
    // R12: reset state
    chk(16'(spi_miso), 16'h0, "R12 miso after reset");
    chk(16'(cfg_active), 16'h00, "R12 cfg_active after reset");
    chk(16'(soft_rst), 16'h0, "R12 soft_rst after reset");
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R3/R8/R4/R7/R9: descending burst 0x0006..0x0000
    for (int i = 0; i < 8; i++) wb[i] = 8'hA5;
    frame(1'b1, 15'h0006, 7, -1);
    for (int i = 0; i < 7; i++)
      chk(16'(rb[i]), 16'(exp_reg(15'(6 - i))), "R3 R8 burst from 0x0006");
    chk(16'(spi_miso), 16'h0, "R2 miso idle after frame");

    // R1/R8/R9: single-byte read sweeps over the internal map
    for (int a = 0; a <= 16'h0020; a++) begin
      rd1(15'(a), d);
      chk(16'(d), 16'(exp_reg(15'(a))), "R1 R9 sweep low");
    end
    for (int a = 16'h00FA; a <= 16'h0104; a++) begin
      rd1(15'(a), d);
      chk(16'(d), 16'(exp_reg(15'(a))), "R1 R9 sweep cfg page");
    end

    // R10: external window burst
    frame(1'b1, 15'h0203, 4, -1);
    for (int i = 0; i < 4; i++)
      chk(16'(rb[i]), 16'(ext_fn(15'(16'h0203 - i))), "R10 external burst read");
    frame(1'b1, 15'h4A17, 2, -1);
    chk(16'(rb[0]), 16'(ext_fn(15'h4A17)), "R10 external read high");
    chk(16'(rb[1]), 16'(ext_fn(15'h4A16)), "R10 external read next");

    // R3: wrap from 0x0000 to 0x7FFF
    frame(1'b1, 15'h0001, 3, -1);
    chk(16'(rb[0]), 16'h00, "R7 option default");
    chk(16'(rb[1]), 16'h18, "R4 interface byte");
    chk(16'(rb[2]), 16'(ext_fn(15'h7FFF)), "R3 wrap to 0x7FFF");

    // R9: writes to read-only and unmapped addresses
    w0 = n_wr;
    wr1(15'h0003, 8'hFF);
    wr1(15'h0002, 8'hAA);
    wr1(15'h000C, 8'h00);
    wr1(15'h0000, 8'h7F);
    rd1(15'h0003, d); chk(16'(d), 16'h07, "R9 read-only kind byte");
    rd1(15'h0002, d); chk(16'(d), 16'h00, "R9 unmapped stays zero");
    rd1(15'h000C, d); chk(16'(d), 16'h51, "R9 read-only vendor byte");
    rd1(15'h0000, d); chk(16'(d), 16'h18, "R4 no change on write");
    chk(16'(n_soft), 16'h0, "R4 no soft reset without bit 7");
    chk(16'(n_wr - w0), 16'h0, "R9 no external write");

    // R6/R7: shadow and live copies
    wr1(15'h0100, 8'h5A); m_buf = 8'h5A;
    chk(16'(cfg_active), 16'h00, "R6 live unchanged by shadow write");
    rd1(15'h0100, d); chk(16'(d), 16'h00, "R7 read of live copy");
    wr1(15'h0001, 8'hFF); m_sel = 1'b1;
    rd1(15'h0001, d); chk(16'(d), 16'h20, "R7 only bit 5 kept");
    rd1(15'h0100, d); chk(16'(d), 16'h5A, "R7 read of shadow copy");
    wr1(15'h000F, 8'h00);
    chk(16'(cfg_active), 16'h00, "R6 commit needs bit 0");
    wr1(15'h000F, 8'h01); m_act = 8'h5A;
    chk(16'(cfg_active), 16'h5A, "R6 commit copies shadow");
    rd1(15'h000F, d); chk(16'(d), 16'h00, "R6 commit reads zero");

    // R11: aborted bytes commit nothing
    wb[0] = 8'hC3;
    frame(1'b0, 15'h0100, 1, 5);
    rd1(15'h0100, d); chk(16'(d), 16'h5A, "R11 aborted shadow write");
    wr1(15'h0100, 8'h66); m_buf = 8'h66;
    wb[0] = 8'h01;
    frame(1'b0, 15'h000F, 1, 7);
    chk(16'(cfg_active), 16'h5A, "R11 aborted commit");

    // R4/R5: soft reset
    wr1(15'h0000, 8'h80); m_buf = 8'h00; m_act = 8'h00;
    chk(16'(n_soft), 16'h1, "R4 soft reset pulse");
    chk(16'(cfg_active), 16'h00, "R5 live copy cleared");
    rd1(15'h0100, d); chk(16'(d), 16'h00, "R5 shadow cleared");
    rd1(15'h0001, d); chk(16'(d), 16'h20, "R5 option byte kept");
    rd1(15'h0000, d); chk(16'(d), 16'h18, "R4 bit 7 self-clears");

    // R10/R3: external write bursts, including the wrap
    w0 = n_wr;
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33;
    frame(1'b0, 15'h0201, 3, -1);
    chk(16'(n_wr - w0), 16'h2, "R10 writes inside window only");
    chk(16'(wl_addr[w0]), 16'h0201, "R10 first write address");
    chk(16'(wl_data[w0]), 16'h11, "R10 first write data");
    chk(16'(wl_addr[w0+1]), 16'h0200, "R3 second write address");
    chk(16'(wl_data[w0+1]), 16'h22, "R10 second write data");
    wb[0] = 8'h00; wb[1] = 8'h77;
    frame(1'b0, 15'h0000, 2, -1);
    chk(16'(wl_addr[w0+2]), 16'h7FFF, "R3 write wrap address");
    chk(16'(wl_data[w0+2]), 16'h77, "R3 write wrap data");
    chk(16'(n_soft), 16'h1, "R4 zero byte gives no soft reset");

    // R2: no output during instruction bits
    chk(16'(cmd_hi), 16'h0, "R2 miso low during instructions");

    // R12: hardware reset mid-operation
    wr1(15'h0100, 8'h3C);
    wr1(15'h000F, 8'h01);
    chk(16'(cfg_active), 16'h3C, "R6 commit before hardware reset");
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    m_sel = 1'b0; m_buf = 8'h00; m_act = 8'h00;
    repeat (3) @(negedge clk);
    chk(16'(cfg_active), 16'h00, "R12 live cleared");
    rd1(15'h0001, d); chk(16'(d), 16'h00, "R12 option cleared");
    wr1(15'h0001, 8'h20); m_sel = 1'b1;
    rd1(15'h0100, d); chk(16'(d), 16'h00, "R12 shadow cleared");

    summary();
  end
endmodule